// File: doc/BRIEF.md
# Two-Port Synchronous SRAM with Cross-Port Forwarding

This block is a synchronous single-clock memory with two fully independent ports, X and Y. Each port has its own address, write enable, forwarding request and data path. All requests are captured on one rising clock edge. In any cycle each port can read the array, write the array, or hand its own input word straight to the opposite port's output without touching the array.

Reads and forwarded words pass through an output register, so they appear one clock edge after the edge that captured the request. Each port's output drive is gated by an output enable that acts without the clock. The bidirectional pins of a board-level part become a data-in, a data-out and a drive-enable per port. The depth is set by an address-width parameter: `ADDR_W = 15` gives the full 32768-word array, and the default of 11 keeps elaboration small.

When both ports name the same address, a fixed rule applies. Two reads both return the stored word. A write paired with a read returns the word from before the write. Two writes leave port Y's word in the array.

Top module: `dpt_sram`

## Requirements
- R1: The array holds 2**ADDR_W words of DATA_W bits. A word written through either port can later be read from that address through either port.
- R2: A cycle is selected only when `cs_lo_n` is 0 and `cs_hi` is 1, both sampled on the rising edge.
- R3: In a cycle that is not selected, nothing is written to the array and neither data output changes.
- R4: Writes are active low: `x_wr_n`=0 stores the captured `x_din` at `x_addr`, and `y_wr_n`=0 stores the captured `y_din` at `y_addr`.
- R5: A port reads the array only when its write enable is 1 and both forwarding inputs are 1.
- R6: `x_pt_n`=0 makes `y_dout` carry the captured `x_din`. Forwarding overrides any read on port Y.
- R7: `y_pt_n`=0 makes `x_dout` carry the captured `y_din`. Forwarding overrides any read on port X.
- R8: When both ports read the same address, both return the stored word.
- R9: When one port writes and the other reads the same address, the reader returns the word from before the write.
- R10: When both ports write the same address in one cycle, only the port Y word is kept.
- R11: Read and forwarded data captured at edge n appear on the data output after edge n+1, and not after edge n.
- R12: `x_drv` and `y_drv` follow the inverse of `x_oe_n` and `y_oe_n` at once, without waiting for a clock edge.
- R13: Reset clears both output registers to zero. A selected cycle in which a port neither reads nor receives forwarded data leaves that port's output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock; all requests are captured on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the control and output registers |
| cs_lo_n | input | 1 | Chip select, active low |
| cs_hi | input | 1 | Chip select, active high |
| x_addr | input | ADDR_W | Port X address |
| y_addr | input | ADDR_W | Port Y address |
| x_wr_n | input | 1 | Port X write enable, active low |
| y_wr_n | input | 1 | Port Y write enable, active low |
| x_pt_n | input | 1 | Forward port X input to port Y output, active low |
| y_pt_n | input | 1 | Forward port Y input to port X output, active low |
| x_din | input | DATA_W | Port X input data |
| y_din | input | DATA_W | Port Y input data |
| x_oe_n | input | 1 | Port X output enable, asynchronous, active low |
| y_oe_n | input | 1 | Port Y output enable, asynchronous, active low |
| x_dout | output | DATA_W | Port X output register |
| y_dout | output | DATA_W | Port Y output register |
| x_drv | output | 1 | Port X output drive enable |
| y_drv | output | 1 | Port Y output drive enable |

## Verification
The hardest case to reach from the ports is a same-address write paired with a read. It is only visible if the address already holds a known, different word, and the next read must show that the write did land. The vector table first stores a word, then writes a new word while the other port reads the same address, and then reads both ports. In that order one sequence shows both the old-data return and the committed write. Deselected cycles carry live write and forward requests, so an ignored request would still show up in the following read.

// File: rtl/dpt_sram.sv
`timescale 1ns/1ps
module dpt_sram #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_lo_n,
  input  logic              cs_hi,
  input  logic [ADDR_W-1:0] x_addr,
  input  logic [ADDR_W-1:0] y_addr,
  input  logic              x_wr_n,
  input  logic              y_wr_n,
  input  logic              x_pt_n,
  input  logic              y_pt_n,
  input  logic [DATA_W-1:0] x_din,
  input  logic [DATA_W-1:0] y_din,
  input  logic              x_oe_n,
  input  logic              y_oe_n,
  output logic [DATA_W-1:0] x_dout,
  output logic [DATA_W-1:0] y_dout,
  output logic              x_drv,
  output logic              y_drv
);
  localparam int DEPTH = 1 << ADDR_W;

  logic              sel_q, xw_q, yw_q, xp_q, yp_q;
  logic [ADDR_W-1:0] xa_q, ya_q;
  logic [DATA_W-1:0] xd_q, yd_q;
  logic [DATA_W-1:0] xo_q, yo_q;
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 1'b0;
      xw_q  <= 1'b0;
      yw_q  <= 1'b0;
      xp_q  <= 1'b0;
      yp_q  <= 1'b0;
    end else begin
      sel_q <= !cs_lo_n && cs_hi;
      xw_q  <= !x_wr_n;
      yw_q  <= !y_wr_n;
      xp_q  <= !x_pt_n;
      yp_q  <= !y_pt_n;
    end
  end

  always_ff @(posedge clk) begin
    xa_q <= x_addr;
    ya_q <= y_addr;
    xd_q <= x_din;
    yd_q <= y_din;
  end

  wire x_rd = sel_q && !xw_q && !xp_q && !yp_q;
  wire y_rd = sel_q && !yw_q && !xp_q && !yp_q;

  always_ff @(posedge clk) begin
    if (sel_q && xw_q) mem[xa_q] <= xd_q;
    if (sel_q && yw_q) mem[ya_q] <= yd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xo_q <= '0;
      yo_q <= '0;
    end else begin
      if (sel_q && yp_q) xo_q <= yd_q;
      else if (x_rd)     xo_q <= mem[xa_q];
      if (sel_q && xp_q) yo_q <= xd_q;
      else if (y_rd)     yo_q <= mem[ya_q];
    end
  end

  assign x_dout = xo_q;
  assign y_dout = yo_q;
  assign x_drv  = !x_oe_n;
  assign y_drv  = !y_oe_n;
endmodule

module dpt_sram_chk #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 36
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_lo_n,
  input logic              cs_hi,
  input logic              x_wr_n,
  input logic              y_wr_n,
  input logic              x_pt_n,
  input logic              y_pt_n,
  input logic [DATA_W-1:0] x_din,
  input logic [DATA_W-1:0] y_din,
  input logic [DATA_W-1:0] x_dout,
  input logic [DATA_W-1:0] y_dout
);
  wire sel = !cs_lo_n && cs_hi;

  AST_DESEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |-> ##2 ($stable(x_dout) && $stable(y_dout))); // R3
  AST_PASS_X_TO_Y: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !x_pt_n) |-> ##2 (y_dout == $past(x_din, 2))); // R6
  AST_PASS_Y_TO_X: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !y_pt_n) |-> ##2 (x_dout == $past(y_din, 2))); // R7
  AST_X_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && y_pt_n && (!x_wr_n || !x_pt_n)) |-> ##2 $stable(x_dout)); // R13
  AST_Y_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && x_pt_n && (!y_wr_n || !y_pt_n)) |-> ##2 $stable(y_dout)); // R13
  AST_RESET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (x_dout == '0 && y_dout == '0)); // R13
endmodule

bind dpt_sram dpt_sram_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_lo_n(cs_lo_n), .cs_hi(cs_hi),
  .x_wr_n(x_wr_n), .y_wr_n(y_wr_n), .x_pt_n(x_pt_n), .y_pt_n(y_pt_n),
  .x_din(x_din), .y_din(y_din), .x_dout(x_dout), .y_dout(y_dout)
);

// File: tb/sim_dpt_sram.sv
`timescale 1ns/1ps
module sim_dpt_sram;
  localparam int AW = 4;
  localparam int DW = 36;
  localparam int NV = 16;

  typedef struct packed {
    logic          csl_n;
    logic          csh;
    logic          wx_n;
    logic          wy_n;
    logic          px_n;
    logic          py_n;
    logic [AW-1:0] ax;
    logic [AW-1:0] ay;
    logic [DW-1:0] dx;
    logic [DW-1:0] dy;
    logic [DW-1:0] ex;
    logic [DW-1:0] ey;
  } vec_t;

  // csl_n csh wx_n wy_n px_n py_n ax ay dx dy expected_x expected_y
  localparam vec_t TBL [NV] = '{
    '{1'b0,1'b1,1'b0,1'b0,1'b1,1'b1, 4'd3, 4'd5, 36'h111, 36'h222, 36'h0,   36'h0  }, // R4 both write
    '{1'b0,1'b1,1'b1,1'b1,1'b1,1'b1, 4'd5, 4'd3, 36'h0,   36'h0,   36'h222, 36'h111}, // R1 R5 cross read
    '{1'b0,1'b1,1'b1,1'b1,1'b1,1'b1, 4'd3, 4'd3, 36'h0,   36'h0,   36'h111, 36'h111}, // R8
    '{1'b0,1'b1,1'b0,1'b1,1'b1,1'b1, 4'd3, 4'd3, 36'h333, 36'h0,   36'h111, 36'h111}, // R9 old data
    '{1'b0,1'b1,1'b1,1'b1,1'b1,1'b1, 4'd3, 4'd3, 36'h0,   36'h0,   36'h333, 36'h333}, // R9 write landed
    '{1'b0,1'b1,1'b0,1'b0,1'b1,1'b1, 4'd7, 4'd7, 36'h444, 36'h555, 36'h333, 36'h333}, // R10
    '{1'b0,1'b1,1'b1,1'b1,1'b1,1'b1, 4'd7, 4'd7, 36'h0,   36'h0,   36'h555, 36'h555}, // R10 Y wins
    '{1'b0,1'b1,1'b1,1'b1,1'b0,1'b1, 4'd3, 4'd5, 36'hABC, 36'h0,   36'h555, 36'hABC}, // R6
    '{1'b0,1'b1,1'b1,1'b1,1'b1,1'b0, 4'd5, 4'd3, 36'h0,   36'hDEF, 36'hDEF, 36'hABC}, // R7 R5
    '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 4'd9, 4'd10,36'hF01, 36'hF02, 36'hF02, 36'hF01}, // R6 R7 with writes
    '{1'b0,1'b1,1'b1,1'b1,1'b1,1'b1, 4'd9, 4'd10,36'h0,   36'h0,   36'hF01, 36'hF02}, // R4
    '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 4'd9, 4'd10,36'hBAD, 36'hBAD, 36'hF01, 36'hF02}, // R2 R3
    '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b1, 4'd9, 4'd10,36'hBAD, 36'hBAD, 36'hF01, 36'hF02}, // R2 R3
    '{1'b0,1'b1,1'b1,1'b1,1'b1,1'b1, 4'd9, 4'd10,36'h0,   36'h0,   36'hF01, 36'hF02}, // R3 no write
    '{1'b0,1'b1,1'b0,1'b0,1'b1,1'b1, 4'd1, 4'd2, 36'h777, 36'h888, 36'hF01, 36'hF02}, // R13 hold
    '{1'b0,1'b1,1'b1,1'b1,1'b1,1'b1, 4'd2, 4'd1, 36'h0,   36'h0,   36'h888, 36'h777}  // R1
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cs_lo_n = 1'b1, cs_hi = 1'b0;
  logic [AW-1:0] x_addr = '0, y_addr = '0;
  logic          x_wr_n = 1'b1, y_wr_n = 1'b1, x_pt_n = 1'b1, y_pt_n = 1'b1;
  logic [DW-1:0] x_din = '0, y_din = '0;
  logic          x_oe_n = 1'b0, y_oe_n = 1'b0;
  logic [DW-1:0] x_dout, y_dout;
  logic          x_drv, y_drv;
  int            n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  dpt_sram #(.ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .cs_lo_n(cs_lo_n), .cs_hi(cs_hi),
    .x_addr(x_addr), .y_addr(y_addr), .x_wr_n(x_wr_n), .y_wr_n(y_wr_n),
    .x_pt_n(x_pt_n), .y_pt_n(y_pt_n), .x_din(x_din), .y_din(y_din),
    .x_oe_n(x_oe_n), .y_oe_n(y_oe_n), .x_dout(x_dout), .y_dout(y_dout),
    .x_drv(x_drv), .y_drv(y_drv)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    cs_lo_n = v.csl_n; cs_hi = v.csh;
    x_wr_n = v.wx_n; y_wr_n = v.wy_n; x_pt_n = v.px_n; y_pt_n = v.py_n;
    x_addr = v.ax; y_addr = v.ay; x_din = v.dx; y_din = v.dy;
  endtask

  task automatic idle();
    cs_lo_n = 1'b1; cs_hi = 1'b0;
    x_wr_n = 1'b1; y_wr_n = 1'b1; x_pt_n = 1'b1; y_pt_n = 1'b1;
  endtask

  task automatic wrap_up();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(4 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    wrap_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R13 reset x", x_dout, '0);
    check("R13 reset y", y_dout, '0);

    for (int i = 0; i < NV; i++) begin
      drive(TBL[i]);
      @(negedge clk);
      idle();
      @(negedge clk);
      check($sformatf("vec%0d x R1-class", i), x_dout, TBL[i].ex);
      check($sformatf("vec%0d y R1-class", i), y_dout, TBL[i].ey);
    end

    // R11: read of 1/2 issued; after one edge outputs still show 888/777
    drive('{1'b0,1'b1,1'b1,1'b1,1'b1,1'b1, 4'd1, 4'd2, 36'h0, 36'h0, 36'h0, 36'h0});
    @(posedge clk);
    #1;
    idle();
    check("R11 x not early", x_dout, 36'h888);
    check("R11 y not early", y_dout, 36'h777);
    @(posedge clk);
    #1;
    check("R11 x at n+1", x_dout, 36'h777);
    check("R11 y at n+1", y_dout, 36'h888);

    // R12: asynchronous output enables
    @(negedge clk);
    x_oe_n = 1'b1; y_oe_n = 1'b0;
    #0.5;
    check("R12 x off", {35'd0, x_drv}, 36'd0);
    check("R12 y on", {35'd0, y_drv}, 36'd1);
    x_oe_n = 1'b0; y_oe_n = 1'b1;
    #0.5;
    check("R12 x on", {35'd0, x_drv}, 36'd1);
    check("R12 y off", {35'd0, y_drv}, 36'd0);
    y_oe_n = 1'b0;

    // R13: reset in mid-run clears outputs
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R13 mid reset x", x_dout, '0);
    check("R13 mid reset y", y_dout, '0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: array content survives output reset
    drive('{1'b0,1'b1,1'b1,1'b1,1'b1,1'b1, 4'd7, 4'd9, 36'h0, 36'h0, 36'h0, 36'h0});
    @(negedge clk);
    idle();
    @(negedge clk);
    check("R1 x readback", x_dout, 36'h555);
    check("R1 y readback", y_dout, 36'hF01);

    wrap_up();
  end
endmodule